// File: doc/BRIEF.md
# State Breakpoint and Signature Recorder

This debug block sits beside a design under test and watches its whole state vector every clock cycle. It drives a clock-enable back to that design. Software first loads a target state through a serial scan chain and arms the block. The design then runs at full speed until its complete state equals the target, and at that point the block stops it. On every cycle in which the design advances, the block also folds the state into a narrow hash signature and keeps a rolling history of the most recent signatures.

When the block has halted, the scan chain shifts out the target, the state that matched and the signature history, and it shifts in the next target in the same pass. The host works out a candidate earlier state from that history, loads it as the new target, re-arms the block and runs the design again. This repeats until each candidate has been reached in turn. The scan chain, the comparator, the hash and the history are all inside the block. Solving for earlier states is done by the host.

Top module: `bpsig_top`

## Requirements
- R1: After reset, runEn is 1, hitFlag is 0 and the breakpoint is not armed.
- R2: While the block is not armed, a state equal to the target never halts the design.
- R3: Once armed, the block checks every running cycle. If stateIn equals the target on all STATE_W bits at a rising edge, hitFlag is 1 and runEn is 0 from that edge on. A state that differs in any single bit, the MSB included, does not halt the design.
- R4: Signature bit i is the XOR of all bits stateIn[j] whose mask bit (i,j) is 1. The mask bit (i,j) is 1 exactly when ((i+1)*(j+1)+i) mod 3 is not 0.
- R5: The history holds the signatures of the last HIST_N states sampled at running edges, the matching edge included. It scans out oldest first, and each signature goes out LSB first.
- R6: The captured state holds the state sampled at the last running edge, so after a halt it holds the matched state.
- R7: While scanEn is 1, each rising edge shifts one chain of STATE_W*2+SIG_W*HIST_N bits. Its layout from LSB to MSB is history, captured state, target. scanOut shows chain bit 0, and scanIn enters the MSB of the target. A full pass therefore unloads the old contents LSB first and leaves the vector that was shifted in.
- R8: While scanEn is 1, runEn is 0, no match is taken, and the captured state and the history take no new state.
- R9: hitFlag stays 1 and the design stays halted until the next arm. An arm clears hitFlag and the halt, and it sets armed.
- R10: armReq is ignored while scanEn is 1.
- R11: After a halt, loading a new target and re-arming lets the design run until that target is reached. It halts on the running edge that samples that target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stateIn | input | STATE_W | Full state vector of the design under test |
| armReq | input | 1 | One-cycle arm pulse |
| scanEn | input | 1 | Selects serial shifting of the debug chain |
| scanIn | input | 1 | Serial data into the target MSB |
| scanOut | output | 1 | Serial data from chain bit 0 |
| runEn | output | 1 | Clock enable to the design under test |
| hitFlag | output | 1 | Sticky breakpoint-hit indication |

## Verification
The bench loads a target that differs from a state that will be reached only in its MSB. A comparator that ignored some bits would halt on that near miss. The bench counts edges exactly to the matching cycle, so a halt that came one cycle early or late, or that forgot to clear the arm, shows up as a wrong runEn or hitFlag value at a known cycle. It pulses armReq in the middle of a scan, so a block that accepted arming during a scan would stop at a target it should pass. It compares the unloaded signatures with hashes of known states, and a wrong mask, a reversed history order or a missing match-cycle entry each give a wrong bit field.

// File: rtl/bpsig_pkg.sv
package bpsig_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic runStep;   // design advances this cycle: capture and push signature
    logic scanStep;  // shift the debug chain by one bit
  } bpStrobe_t;

  // Fixed pseudo-random GF(2) hash mask
  function automatic logic maskBit(input int row, input int col);
    return (((row + 1) * (col + 1) + row) % 3) != 0;
  endfunction

endpackage

// File: rtl/bpsig_hash.sv
module bpsig_hash
  import bpsig_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int SIG_W   = 4
) (
  input  logic [STATE_W-1:0] stateVec,
  output logic [SIG_W-1:0]   sigVec
);

  for (genvar gi = 0; gi < SIG_W; gi++) begin : gRow
    logic [STATE_W-1:0] rowMask;
    always_comb begin
      for (int j = 0; j < STATE_W; j++) rowMask[j] = maskBit(gi, j);
    end
    assign sigVec[gi] = ^(stateVec & rowMask);
  end

endmodule

// File: rtl/bpsig_ctrl.sv
module bpsig_ctrl
  import bpsig_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      armReq,
  input  logic      scanEn,
  input  logic      eqNow,
  output bpStrobe_t strobe,
  output logic      runEn,
  output logic      hitFlag
);

  logic armedQ;
  logic haltQ;
  logic hitQ;

  assign runEn          = !haltQ && !scanEn;
  assign hitFlag        = hitQ;
  assign strobe.runStep  = runEn;
  assign strobe.scanStep = scanEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      haltQ  <= 1'b0;
      hitQ   <= 1'b0;
    end else if (!scanEn) begin
      if (armReq) begin
        armedQ <= 1'b1;
        haltQ  <= 1'b0;
        hitQ   <= 1'b0;
      end else if (!haltQ && armedQ && eqNow) begin
        armedQ <= 1'b0;
        haltQ  <= 1'b1;
        hitQ   <= 1'b1;
      end
    end
  end

  // R3: armed full match halts from the next cycle and disarms
  a_r3_halt_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && armedQ && eqNow && !armReq) |=> (!runEn && hitFlag && !armedQ));

  // R2: an unarmed block never enters halt
  a_r2_no_halt_unarmed: assert property (@(posedge clk) disable iff (!rstN)
    (!armedQ && !armReq) |=> $stable(haltQ));

  // R9: hit only drops through an accepted arm
  a_r9_sticky_hit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hitFlag) |-> ($past(armReq) && !$past(scanEn)));

  // R10: scanning freezes the control state
  a_r10_scan_freezes_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> ($stable(armedQ) && $stable(haltQ) && $stable(hitQ)));

endmodule

// File: rtl/bpsig_datapath.sv
module bpsig_datapath
  import bpsig_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int SIG_W   = 4,
  parameter int HIST_N  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  bpStrobe_t          strobe,
  input  logic [STATE_W-1:0] stateIn,
  input  logic               scanIn,
  output logic               scanOut,
  output logic               eqNow
);

  localparam int HIST_W = SIG_W * HIST_N;

  logic [STATE_W-1:0] targetQ;
  logic [STATE_W-1:0] capQ;
  logic [HIST_W-1:0]  histQ;
  logic [HIST_W-1:0]  histPush;
  logic [SIG_W-1:0]   sigNow;

  bpsig_hash #(.STATE_W(STATE_W), .SIG_W(SIG_W)) u_hash (
    .stateVec (stateIn),
    .sigVec   (sigNow)
  );

  // newest signature enters at the top, oldest sits at bit 0
  if (HIST_N == 1) begin : gHistOne
    assign histPush = sigNow;
  end else begin : gHistMany
    assign histPush = {sigNow, histQ[HIST_W-1:SIG_W]};
  end

  assign eqNow   = (stateIn == targetQ);
  assign scanOut = histQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetQ <= '0;
      capQ    <= '0;
      histQ   <= '0;
    end else if (strobe.scanStep) begin
      targetQ <= {scanIn, targetQ[STATE_W-1:1]};
      capQ    <= {targetQ[0], capQ[STATE_W-1:1]};
      histQ   <= {capQ[0], histQ[HIST_W-1:1]};
    end else if (strobe.runStep) begin
      capQ  <= stateIn;
      histQ <= histPush;
    end
  end

  // R6: a running edge captures the sampled state
  a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runStep && !strobe.scanStep) |=> (capQ == $past(stateIn)));

  // R5: the newest history slot holds the hash of the sampled state
  a_r5_newest_sig: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runStep && !strobe.scanStep) |=> (histQ[HIST_W-1 -: SIG_W] == $past(sigNow)));

  // R8: halted and not scanning keeps every record
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.runStep && !strobe.scanStep) |=> ($stable(capQ) && $stable(histQ)));

  // R7: the target changes only through the scan chain
  a_r7_target_scan_only: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.scanStep |=> $stable(targetQ));

endmodule

// File: rtl/bpsig_top.sv
module bpsig_top
  import bpsig_pkg::*;
#(
  parameter int STATE_W = 16,
  parameter int SIG_W   = 4,
  parameter int HIST_N  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] stateIn,
  input  logic               armReq,
  input  logic               scanEn,
  input  logic               scanIn,
  output logic               scanOut,
  output logic               runEn,
  output logic               hitFlag
);

  bpStrobe_t strobe;
  logic      eqNow;

  bpsig_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .armReq  (armReq),
    .scanEn  (scanEn),
    .eqNow   (eqNow),
    .strobe  (strobe),
    .runEn   (runEn),
    .hitFlag (hitFlag)
  );

  bpsig_datapath #(.STATE_W(STATE_W), .SIG_W(SIG_W), .HIST_N(HIST_N)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stateIn (stateIn),
    .scanIn  (scanIn),
    .scanOut (scanOut),
    .eqNow   (eqNow)
  );

endmodule

// File: tb/bpsig_top_tb.sv
module bpsig_top_tb;

  localparam int STATE_W = 16;
  localparam int SIG_W   = 4;
  localparam int HIST_N  = 4;
  localparam int HIST_W  = SIG_W * HIST_N;
  localparam int CHAIN_W = 2 * STATE_W + HIST_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [STATE_W-1:0] stateIn;
  logic armReq = 1'b0;
  logic scanEn = 1'b0;
  logic scanIn = 1'b0;
  logic scanOut, runEn, hitFlag;

  int checks = 0;
  int errors = 0;
  logic [CHAIN_W-1:0] expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  bpsig_top #(.STATE_W(STATE_W), .SIG_W(SIG_W), .HIST_N(HIST_N)) u_dut (
    .clk(clk), .rstN(rstN), .stateIn(stateIn), .armReq(armReq),
    .scanEn(scanEn), .scanIn(scanIn), .scanOut(scanOut),
    .runEn(runEn), .hitFlag(hitFlag)
  );

  // Model of the design under test: advances only when enabled
  always @(posedge clk or negedge rstN) begin
    if (!rstN) stateIn <= 16'h1234;
    else if (runEn) stateIn <= STATE_W'(stateIn * 5 + 3);
  end

  function automatic logic [STATE_W-1:0] adv(input logic [STATE_W-1:0] s, input int n);
    logic [STATE_W-1:0] v = s;
    for (int k = 0; k < n; k++) v = STATE_W'(v * 5 + 3);
    return v;
  endfunction

  // R4 hash from its stated mask formula
  function automatic logic [SIG_W-1:0] sigOf(input logic [STATE_W-1:0] s);
    logic [SIG_W-1:0] r = '0;
    for (int i = 0; i < SIG_W; i++)
      for (int j = 0; j < STATE_W; j++)
        if ((((i + 1) * (j + 1) + i) % 3) != 0) r[i] = r[i] ^ s[j];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulseArm();
    armReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    armReq = 1'b0;
  endtask

  // Driver: shifts a full chain pass, optionally pulsing arm at one bit
  task automatic scanPass(input logic [CHAIN_W-1:0] inVec, input int armAt,
                          output logic [CHAIN_W-1:0] outVec);
    bit ranDuring = 1'b0;
    scanEn = 1'b1;
    for (int k = 0; k < CHAIN_W; k++) begin
      scanIn = inVec[k];
      armReq = (k == armAt);
      #1;
      outVec[k] = scanOut;
      if (runEn) ranDuring = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    scanEn = 1'b0;
    armReq = 1'b0;
    check(!ranDuring, "R8 runEn low while scanning", 64'(ranDuring), 64'd0);
  endtask

  // Monitor: pops the expected chain and compares field by field
  task automatic compareScan(input logic [CHAIN_W-1:0] got);
    logic [CHAIN_W-1:0] exp = expQ.pop_front();
    check(got[CHAIN_W-1 -: STATE_W] == exp[CHAIN_W-1 -: STATE_W], "R7 target field",
          64'(got[CHAIN_W-1 -: STATE_W]), 64'(exp[CHAIN_W-1 -: STATE_W]));
    check(got[HIST_W +: STATE_W] == exp[HIST_W +: STATE_W], "R6 captured state",
          64'(got[HIST_W +: STATE_W]), 64'(exp[HIST_W +: STATE_W]));
    check(got[HIST_W-1:0] == exp[HIST_W-1:0], "R4 R5 signature history",
          64'(got[HIST_W-1:0]), 64'(exp[HIST_W-1:0]));
  endtask

  function automatic logic [CHAIN_W-1:0] expChain(input logic [STATE_W-1:0] tgt,
                                                   input logic [STATE_W-1:0] matched);
    logic [HIST_W-1:0] h;
    for (int i = 0; i < HIST_N; i++)
      h[i*SIG_W +: SIG_W] = sigOf(adv(matched, 0) == matched ?
                                  stateBack(matched, HIST_N - 1 - i) : matched);
    return {tgt, matched, h};
  endfunction

  // state reached n steps before m, found by forward search from a known origin
  logic [STATE_W-1:0] origin;
  function automatic logic [STATE_W-1:0] stateBack(input logic [STATE_W-1:0] m, input int n);
    logic [STATE_W-1:0] v = origin;
    for (int k = 0; k < 200; k++) begin
      if (adv(v, n) == m) return v;
      v = adv(v, 1);
    end
    return '0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CHAIN_W-1:0] got;
    logic [STATE_W-1:0] cur, t1, t2, t3, t4, frozen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(runEn == 1'b1, "R1 runEn after reset", 64'(runEn), 64'd1);
    check(hitFlag == 1'b0, "R1 hitFlag after reset", 64'(hitFlag), 64'd0);

    step(5);
    check(runEn == 1'b1, "R2 unarmed keeps running", 64'(runEn), 64'd1);

    // Load a reachable target with an arm pulse mid-scan (must be ignored)
    cur = stateIn;
    t1 = adv(cur, 20);
    scanPass({t1, {(CHAIN_W-STATE_W){1'b0}}}, 5, got);
    step(40);
    check(runEn == 1'b1 && hitFlag == 1'b0, "R10 R2 arm during scan ignored",
          64'({runEn, hitFlag}), 64'b10);

    // Arm, then a target differing only in its MSB from a reachable state
    pulseArm();
    cur = stateIn;
    t2 = adv(cur, 8) ^ 16'h8000;
    scanPass({t2, {(CHAIN_W-STATE_W){1'b0}}}, -1, got);
    step(30);
    check(runEn == 1'b1 && hitFlag == 1'b0, "R3 single-bit near miss",
          64'({runEn, hitFlag}), 64'b10);

    // Exact target twelve steps ahead
    cur = stateIn;
    t3 = adv(cur, 12);
    scanPass({t3, {(CHAIN_W-STATE_W){1'b0}}}, -1, got);
    step(12);
    check(runEn == 1'b1 && hitFlag == 1'b0, "R3 no early halt",
          64'({runEn, hitFlag}), 64'b10);
    step(1);
    check(runEn == 1'b0 && hitFlag == 1'b1, "R3 halt on match",
          64'({runEn, hitFlag}), 64'b01);
    step(10);
    check(runEn == 1'b0 && hitFlag == 1'b1, "R9 hit sticky while halted",
          64'({runEn, hitFlag}), 64'b01);

    frozen = stateIn;
    check(frozen == adv(cur, 13), "R8 design frozen after halt", 64'(frozen),
          64'(adv(cur, 13)));
    origin = cur;
    expQ.push_back(expChain(t3, t3));
    t4 = adv(frozen, 7);
    scanPass({t4, {(CHAIN_W-STATE_W){1'b0}}}, -1, got);
    compareScan(got);
    check(stateIn == frozen, "R8 no advance during scan", 64'(stateIn), 64'(frozen));
    check(hitFlag == 1'b1, "R9 hit survives scan", 64'(hitFlag), 64'd1);

    // Re-arm and run to the new candidate
    pulseArm();
    check(hitFlag == 1'b0 && runEn == 1'b1, "R9 arm clears hit and halt",
          64'({runEn, hitFlag}), 64'b10);
    step(7);
    check(runEn == 1'b1 && hitFlag == 1'b0, "R11 not before new target",
          64'({runEn, hitFlag}), 64'b10);
    step(1);
    check(runEn == 1'b0 && hitFlag == 1'b1, "R11 halt on new target",
          64'({runEn, hitFlag}), 64'b01);

    origin = frozen;
    expQ.push_back(expChain(t4, t4));
    scanPass('0, -1, got);
    compareScan(got);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule